// File: doc/BRIEF.md
# Fail-Safe Clock Source Controller

This block picks which of four clock source groups drives the system clock: the fast internal RC, the low-power internal RC, the primary oscillator and the secondary oscillator. It also guards the active source. The monitor counts reference cycles between edge strobes of the running group. If the strobes stop, or the group is still not valid when the power-up timer ends, the block takes over. It forces the fast internal RC onto the select output, latches a sticky fail flag, drops any pending switch request and pulses a trap line for one cycle.

Software moves between groups through a 16-bit control register. It writes the wanted group into a request field and sets an enable bit. The move finishes once the target group reports valid for a fixed number of consecutive reference cycles. Software can cancel the move by clearing the enable bit before that happens. A configuration mode turns off both the monitor and switching, and the register then only mirrors the configured group. Oscillators are not modelled: each group is represented by a valid level and an edge strobe sampled on the reference clock.

Top module: `clk_failover_top`

## Requirements
- R1: While `rst` is high, and at the first edge after it falls, the current-group and requested-group fields both hold `cfg_group_i`, the fail flag and enable bit are 0, and `trap_o` is 0.
- R2: Group codes are 0 = fast RC, 1 = low-power RC, 2 = primary, 3 = secondary. Register read layout: current group at bits 13:12 (read-only), requested group at bits 9:8 (read/write), PLL lock at bit 5 (live copy of `pll_lock_i`), fail flag at bit 3, enable at bit 0. All other bits read 0. A write to bits 13:12 has no effect.
- R3: In enabled mode, writing enable=1 while enable is 0 starts a switch to the group in write bits 9:8. The switch completes at the second consecutive clock edge that samples that group's `src_valid_i` bit high. At that edge the current group and `clk_sel_o` take the target, and the enable bit clears.
- R4: Writing enable=0 while a switch is pending aborts it. The current group stays unchanged even if the target later becomes valid.
- R5: In enabled mode, with `pwrt_done_i` high, `sleep_i` low and a current group other than fast RC, a takeover happens at the WIN_CYC-th consecutive edge (default 4) that samples no strobe from the current group. A takeover sets current group = 0, fail flag = 1 and enable = 0.
- R6: At the edge where `pwrt_done_i` is first sampled high, a takeover happens if the current group is not fast RC and its `src_valid_i` bit is low. Before that edge, no takeover happens.
- R7: While `sleep_i` is high, no takeover happens and the missing-edge count restarts.
- R8: The fail flag stays set until a register write with bit 3 = 0. Writing bit 3 = 1 leaves it unchanged.
- R9: When `cfg_mode_i[1]` is 1 (disabled mode), the current group follows `cfg_group_i` one edge later. Writes to the enable bit are ignored and no takeover or trap occurs.
- R10: `trap_o` is high for exactly the one cycle after a takeover edge. A takeover overrides a pending switch, which does not complete afterwards.
- R11: `clk_sel_o` always equals the current-group field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (low-power RC domain) |
| rst | input | 1 | Synchronous active-high power-on/brown-out reset |
| cfg_group_i | input | 2 | Configured reset-time group |
| cfg_mode_i | input | 2 | Monitor mode; bit 1 set disables monitor and switching |
| sleep_i | input | 1 | Sleep state, suppresses monitoring |
| pwrt_done_i | input | 1 | Power-up timer expired |
| pll_lock_i | input | 1 | PLL lock status, reported in register |
| src_valid_i | input | 4 | Per-group clock valid level |
| src_tick_i | input | 4 | Per-group edge strobe, sampled on clk |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| clk_sel_o | output | 2 | Selected clock group |
| trap_o | output | 1 | One-cycle clock-fail trap pulse |

## Verification
A table of strobe gaps is applied just below, at and above the window length, including a zero gap. This separates an off-by-one window from a correct one. Separate patterns cover the power-up-timer expiry with a dead source, strobes stopping while asleep and then waking, and a switch whose target becomes valid only late. These tell the expiry detector, the sleep gating and the valid-settle count apart. Abort, a takeover during a pending switch, disabled mode and writes to read-only fields show that each control path alone moves the current group.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int GRP_W = 2;
  localparam int NGRP  = 1 << GRP_W;
  localparam int REG_W = 16;

  localparam logic [GRP_W-1:0] GRP_FRC  = 2'd0;
  localparam logic [GRP_W-1:0] GRP_LPRC = 2'd1;
  localparam logic [GRP_W-1:0] GRP_PRI  = 2'd2;
  localparam logic [GRP_W-1:0] GRP_SEC  = 2'd3;

  localparam int CUR_LSB  = 12;
  localparam int REQ_LSB  = 8;
  localparam int LOCK_BIT = 5;
  localparam int FAIL_BIT = 3;
  localparam int EN_BIT   = 0;
endpackage

// File: rtl/fcs_monitor.sv
module fcs_monitor
  import fcs_pkg::*;
#(
  parameter int WIN_CYC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_on,
  input  logic             sleep_i,
  input  logic             pwrt_done_i,
  input  logic             restart_i,
  input  logic [GRP_W-1:0] cur_grp,
  input  logic [NGRP-1:0]  src_valid_i,
  input  logic [NGRP-1:0]  src_tick_i,
  output logic             fail_o
);
  localparam int CNT_W = $clog2(WIN_CYC + 1);

  logic [CNT_W-1:0] miss_cnt;
  logic             pwrt_q;
  logic             guard;
  logic             watch;
  logic             tick_seen;
  logic             win_fail;
  logic             pwrt_fail;

  assign guard     = mode_on && !sleep_i && (cur_grp != GRP_FRC);
  assign watch     = guard && pwrt_done_i;
  assign tick_seen = src_tick_i[cur_grp];
  assign win_fail  = watch && !tick_seen && (miss_cnt == CNT_W'(WIN_CYC - 1));
  assign pwrt_fail = guard && pwrt_done_i && !pwrt_q && !src_valid_i[cur_grp];
  assign fail_o    = win_fail || pwrt_fail;

  always_ff @(posedge clk) begin
    if (rst) begin
      miss_cnt <= '0;
      pwrt_q   <= 1'b0;
    end else begin
      pwrt_q <= pwrt_done_i;
      if (!watch || tick_seen || fail_o || restart_i)
        miss_cnt <= '0;
      else
        miss_cnt <= miss_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fcs_switch.sv
module fcs_switch
  import fcs_pkg::*;
#(
  parameter int SETTLE_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             busy_i,
  input  logic [GRP_W-1:0] tgt_grp,
  input  logic [NGRP-1:0]  src_valid_i,
  output logic             done_o
);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  logic [SET_W-1:0] run_cnt;
  logic             tgt_ok;

  assign tgt_ok = src_valid_i[tgt_grp];
  assign done_o = busy_i && tgt_ok && (run_cnt == SET_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst || !busy_i || !tgt_ok || done_o)
      run_cnt <= '0;
    else
      run_cnt <= run_cnt + 1'b1;
  end
endmodule

// File: rtl/fcs_regs.sv
module fcs_regs
  import fcs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [GRP_W-1:0] cfg_group_i,
  input  logic             mode_on,
  input  logic             fail_req,
  input  logic             sw_done,
  input  logic             pll_lock_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic [GRP_W-1:0] cur_grp,
  output logic [GRP_W-1:0] tgt_grp,
  output logic             sw_en,
  output logic             trap_o
);
  logic [GRP_W-1:0] req_grp;
  logic             fail_flag;
  logic [GRP_W-1:0] wr_grp;
  logic             wr_en;
  logic             wr_fail;
  logic             unused_wbits;

  assign wr_grp  = reg_wdata_i[REQ_LSB +: GRP_W];
  assign wr_en   = reg_wdata_i[EN_BIT];
  assign wr_fail = reg_wdata_i[FAIL_BIT];
  assign unused_wbits = ^{reg_wdata_i[REG_W-1:REQ_LSB+GRP_W],
                          reg_wdata_i[REQ_LSB-1:FAIL_BIT+1],
                          reg_wdata_i[FAIL_BIT-1:EN_BIT+1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_grp   <= cfg_group_i;
      req_grp   <= cfg_group_i;
      tgt_grp   <= cfg_group_i;
      sw_en     <= 1'b0;
      fail_flag <= 1'b0;
      trap_o    <= 1'b0;
    end else begin
      trap_o <= 1'b0;
      if (reg_we_i) req_grp <= wr_grp;
      if (reg_we_i && !wr_fail) fail_flag <= 1'b0;
      if (!mode_on) begin
        cur_grp <= cfg_group_i;
        sw_en   <= 1'b0;
      end else if (fail_req) begin
        cur_grp   <= GRP_FRC;
        fail_flag <= 1'b1;
        sw_en     <= 1'b0;
        trap_o    <= 1'b1;
      end else if (sw_done) begin
        cur_grp <= tgt_grp;
        sw_en   <= 1'b0;
      end else if (reg_we_i) begin
        sw_en <= wr_en;
        if (wr_en && !sw_en) tgt_grp <= wr_grp;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    reg_rdata_o[CUR_LSB +: GRP_W] = cur_grp;
    reg_rdata_o[REQ_LSB +: GRP_W] = req_grp;
    reg_rdata_o[LOCK_BIT]         = pll_lock_i;
    reg_rdata_o[FAIL_BIT]         = fail_flag;
    reg_rdata_o[EN_BIT]           = sw_en;
  end
endmodule

// File: rtl/clk_failover_top.sv
module clk_failover_top
  import fcs_pkg::*;
#(
  parameter int WIN_CYC    = 4,
  parameter int SETTLE_CYC = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfg_group_i,
  input  logic [1:0]  cfg_mode_i,
  input  logic        sleep_i,
  input  logic        pwrt_done_i,
  input  logic        pll_lock_i,
  input  logic [3:0]  src_valid_i,
  input  logic [3:0]  src_tick_i,
  input  logic        reg_we_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  output logic [1:0]  clk_sel_o,
  output logic        trap_o
);
  logic             mode_on;
  logic             fail_req;
  logic             sw_done;
  logic             sw_en;
  logic [GRP_W-1:0] cur_grp;
  logic [GRP_W-1:0] tgt_grp;
  logic             unused_mode;

  assign mode_on     = !cfg_mode_i[1];
  assign unused_mode = cfg_mode_i[0];
  assign clk_sel_o   = cur_grp;

  fcs_monitor #(.WIN_CYC(WIN_CYC)) mon_i (
    .clk         (clk),
    .rst         (rst),
    .mode_on     (mode_on),
    .sleep_i     (sleep_i),
    .pwrt_done_i (pwrt_done_i),
    .restart_i   (sw_done),
    .cur_grp     (cur_grp),
    .src_valid_i (src_valid_i),
    .src_tick_i  (src_tick_i),
    .fail_o      (fail_req)
  );

  fcs_switch #(.SETTLE_CYC(SETTLE_CYC)) sw_i (
    .clk         (clk),
    .rst         (rst),
    .busy_i      (sw_en),
    .tgt_grp     (tgt_grp),
    .src_valid_i (src_valid_i),
    .done_o      (sw_done)
  );

  fcs_regs regs_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_group_i (cfg_group_i),
    .mode_on     (mode_on),
    .fail_req    (fail_req),
    .sw_done     (sw_done),
    .pll_lock_i  (pll_lock_i),
    .reg_we_i    (reg_we_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .cur_grp     (cur_grp),
    .tgt_grp     (tgt_grp),
    .sw_en       (sw_en),
    .trap_o      (trap_o)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  cfg_mode_i,
  input logic        reg_we_i,
  input logic [15:0] reg_wdata_i,
  input logic [15:0] reg_rdata_o,
  input logic [1:0]  clk_sel_o,
  input logic        trap_o
);
  // R10: trap lasts a single cycle
  p_trap_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    trap_o |=> !trap_o);

  // R5: a trap is seen together with the full takeover state
  p_takeover_state_r5: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (clk_sel_o == 2'd0) && reg_rdata_o[3] && !reg_rdata_o[0]);

  // R8: fail flag only drops after a clearing write
  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rdata_o[3] && !(reg_we_i && !reg_wdata_i[3])) |=> reg_rdata_o[3]);

  // R9: disabled mode never traps and never holds enable
  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_mode_i[1] |=> (!trap_o && !reg_rdata_o[0]));

  // R3: in enabled mode a change of the selected group leaves enable clear
  p_sel_change_clears_en_r3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(clk_sel_o) && !$past(cfg_mode_i[1])) |-> !reg_rdata_o[0]);
endmodule

bind clk_failover_top fcs_checker chk_i (
  .clk         (clk),
  .rst         (rst),
  .cfg_mode_i  (cfg_mode_i),
  .reg_we_i    (reg_we_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .clk_sel_o   (clk_sel_o),
  .trap_o      (trap_o)
);

// File: tb/clk_failover_top_tb_top.sv
`timescale 1ns/1ps
module clk_failover_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_group_i = 2'd2;
  logic [1:0]  cfg_mode_i = 2'b00;
  logic        sleep_i = 1'b0;
  logic        pwrt_done_i = 1'b1;
  logic        pll_lock_i = 1'b0;
  logic [3:0]  src_valid_i = 4'hF;
  logic [3:0]  src_tick_i = 4'hF;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic [1:0]  clk_sel_o;
  logic        trap_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_failover_top dut_i (.*);

  localparam int NTAB = 5;
  localparam int GAP_TAB [NTAB] = '{3, 4, 1, 7, 0};
  localparam int EXP_TAB [NTAB] = '{0, 1, 0, 1, 0};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reset_to(input logic [1:0] grp, input logic [1:0] mode, input logic pw);
    @(negedge clk);
    rst = 1'b1; cfg_group_i = grp; cfg_mode_i = mode; pwrt_done_i = pw;
    sleep_i = 1'b0; pll_lock_i = 1'b0; src_valid_i = 4'hF; src_tick_i = 4'hF;
    reg_we_i = 1'b0; reg_wdata_i = '0;
    step(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    reg_we_i = 1'b1; reg_wdata_i = d;
    step(1);
    reg_we_i = 1'b0; reg_wdata_i = '0;
  endtask

  initial begin
    // R1 reset state
    reset_to(2'd2, 2'b00, 1'b1);
    check("R1 reset rdata", reg_rdata_o, 16'h2200);
    check("R11 sel after reset", {14'd0, clk_sel_o}, 16'd2);
    check("R1 trap low", {15'd0, trap_o}, 16'd0);
    step(1);
    check("R1 first edge rdata", reg_rdata_o, 16'h2200);

    // R5 table of strobe gaps
    for (int i = 0; i < NTAB; i++) begin
      reset_to(2'd2, 2'b00, 1'b1);
      src_tick_i = 4'h0;
      step(GAP_TAB[i]);
      src_tick_i = 4'hF;
      step(1);
      check("R5 fail flag vs gap", {15'd0, reg_rdata_o[3]}, 16'(EXP_TAB[i]));
      check("R5 sel vs gap", {14'd0, clk_sel_o}, (EXP_TAB[i] != 0) ? 16'd0 : 16'd2);
    end

    // R10 trap pulse width, R5 takeover
    reset_to(2'd2, 2'b00, 1'b1);
    src_tick_i = 4'h0;
    step(3);
    check("R10 no trap before window", {15'd0, trap_o}, 16'd0);
    step(1);
    check("R10 trap high", {15'd0, trap_o}, 16'd1);
    check("R5 takeover rdata", reg_rdata_o, 16'h0208);
    step(1);
    check("R10 trap one cycle", {15'd0, trap_o}, 16'd0);

    // R8 sticky fail flag
    step(3);
    check("R8 flag held", {15'd0, reg_rdata_o[3]}, 16'd1);
    wr(16'h0008);
    check("R8 write one no effect", {15'd0, reg_rdata_o[3]}, 16'd1);
    wr(16'h0000);
    check("R8 write zero clears", {15'd0, reg_rdata_o[3]}, 16'd0);

    // R3 switch with late-valid target
    reset_to(2'd2, 2'b00, 1'b1);
    src_valid_i = 4'b0111;
    wr(16'h0301);
    check("R3 enable set", reg_rdata_o, 16'h2301);
    step(3);
    check("R3 waits for valid", {14'd0, clk_sel_o}, 16'd2);
    src_valid_i = 4'hF;
    step(1);
    check("R3 one valid edge not enough", {14'd0, clk_sel_o}, 16'd2);
    step(1);
    check("R3 switch done rdata", reg_rdata_o, 16'h3300);
    check("R11 sel follows", {14'd0, clk_sel_o}, 16'd3);

    // R4 abort
    src_valid_i = 4'b1101;
    wr(16'h0101);
    check("R4 pending", {15'd0, reg_rdata_o[0]}, 16'd1);
    wr(16'h0100);
    check("R4 enable cleared", {15'd0, reg_rdata_o[0]}, 16'd0);
    src_valid_i = 4'hF;
    step(4);
    check("R4 group unchanged", {14'd0, clk_sel_o}, 16'd3);

    // R2 read-only current field and lock bit
    wr(16'h1000);
    check("R2 current field read-only", reg_rdata_o, 16'h3000);
    pll_lock_i = 1'b1;
    #1;
    check("R2 lock bit", reg_rdata_o, 16'h3020);

    // R6 power-up timer expiry with dead source
    reset_to(2'd2, 2'b00, 1'b0);
    src_valid_i = 4'b1011;
    src_tick_i = 4'h0;
    step(6);
    check("R6 no fail before expiry", {15'd0, reg_rdata_o[3]}, 16'd0);
    pwrt_done_i = 1'b1;
    step(1);
    check("R6 trap at expiry", {15'd0, trap_o}, 16'd1);
    check("R6 sel fast rc", {14'd0, clk_sel_o}, 16'd0);

    // R7 sleep suppresses detection
    reset_to(2'd2, 2'b00, 1'b1);
    sleep_i = 1'b1;
    src_tick_i = 4'h0;
    step(8);
    check("R7 no fail asleep", {15'd0, reg_rdata_o[3]}, 16'd0);
    sleep_i = 1'b0;
    step(3);
    check("R7 count restarted", {15'd0, reg_rdata_o[3]}, 16'd0);
    step(1);
    check("R7 fail after wake", {15'd0, reg_rdata_o[3]}, 16'd1);

    // R9 disabled mode
    reset_to(2'd2, 2'b10, 1'b1);
    src_tick_i = 4'h0;
    step(8);
    check("R9 no takeover", reg_rdata_o, 16'h2200);
    wr(16'h0301);
    check("R9 enable ignored", reg_rdata_o, 16'h2300);
    cfg_group_i = 2'd1;
    step(1);
    check("R9 follows config", {14'd0, clk_sel_o}, 16'd1);

    // R10 takeover beats pending switch
    reset_to(2'd2, 2'b00, 1'b1);
    src_valid_i = 4'b0111;
    wr(16'h0301);
    src_tick_i = 4'h0;
    step(4);
    check("R10 takeover over switch", reg_rdata_o, 16'h0308);
    src_valid_i = 4'hF;
    step(3);
    check("R10 switch not resumed", {14'd0, clk_sel_o}, 16'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule